// File: doc/BRIEF.md
# Dual-Source Interrupt Level and Vector Unit

This block joins two serial engines, one SPI-style and one UART-style, to a processor interrupt interface. Software gives each engine a 3-bit priority level and loads one shared 8-bit vector. The block combines the request lines from the two engines with their levels. It presents the highest pending level to the interrupt controller.

When the processor runs an acknowledge cycle for a level, the block checks whether one of its pending sources has that level. If one does, the block answers with the shared vector, with bit 0 set by hardware: 1 when the SPI source is serviced and 0 when the UART source is serviced. The two engines therefore land on two adjacent vectors. When both sources match, the SPI source wins. The vector for a cycle is captured when the cycle starts.

The acknowledge sequencer has three states. `ACK_IDLE` waits for `ack_start`. On `ack_start` it moves to `ACK_SERVE` if a pending source matches `ack_level`, and to `ACK_MISS` if none does. Both `ACK_SERVE` and `ACK_MISS` return to `ACK_IDLE` on `ack_end`. While the sequencer is in `ACK_SERVE` or `ACK_MISS`, `ack_start` has no effect.

Top module: `irq_pair_vec`

## Requirements
- R1: After reset, both level fields read 0, so both sources are disabled. The vector register reads 0x0F. No acknowledge response is active.
- R2: Register select 0 is the SPI level and select 1 is the UART level. A write stores `reg_wdata[2:0]`, and a read returns that field zero-extended to 8 bits. Select 3 reads 0.
- R3: Register select 2 is the vector. A write stores bits 7:1 and ignores bit 0. A read returns the stored bits 7:1 with bit 0 always 1.
- R4: A request counts only while its source's level is nonzero. `irq_level` is the largest level among the counted requests, or 0 when no request counts.
- R5: An `ack_start` in `ACK_IDLE` whose `ack_level` equals the level of a counted request sets `ack_hit` from the next cycle. `ack_vector` is then vector bits 7:1 followed by bit 0, where bit 0 is 1 for the SPI source and 0 for the UART source.
- R6: When both sources match the acknowledged level, `ack_vector[0]` is 1, meaning the SPI source is serviced.
- R7: An `ack_start` whose level matches no counted request enters `ACK_MISS`. There, `ack_hit` is 0 and `ack_vector` is 0.
- R8: The vector for an acknowledge cycle is fixed when the cycle starts. Request changes during the cycle do not alter it.
- R9: `ack_end` returns the sequencer to `ACK_IDLE`, with `ack_hit` low from the next cycle. An `ack_start` while a cycle is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 SPI level, 1 UART level, 2 vector |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| spi_req | input | 1 | Interrupt request from the SPI engine |
| uart_req | input | 1 | Interrupt request from the UART engine |
| irq_level | output | 3 | Highest pending level, 0 when none |
| ack_start | input | 1 | Opens an acknowledge cycle |
| ack_level | input | 3 | Level being acknowledged |
| ack_end | input | 1 | Closes the acknowledge cycle |
| ack_hit | output | 1 | Block is answering the current acknowledge cycle |
| ack_vector | output | 8 | Vector for the serviced source, 0 when not answering |

## Verification
The hardest case to reach is a request that changes while an acknowledge cycle is open. The bench first opens a cycle that only the UART source matches. It then raises the SPI request at the same level mid-cycle and confirms that the vector still names the UART source. It also sends a second `ack_start` inside an open cycle to confirm that it is ignored. Exact level ties are set up by programming both level fields to the same value before raising both requests together.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
    localparam int LVL_W = 3;
    localparam int VEC_W = 8;
    localparam int NSRC  = 2;
    localparam int SRC_SPI  = 0;
    localparam int SRC_UART = 1;

    localparam logic [1:0] SEL_SPI_LVL  = 2'd0;
    localparam logic [1:0] SEL_UART_LVL = 2'd1;
    localparam logic [1:0] SEL_VECTOR   = 2'd2;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_SERVE = 2'd1,
        ACK_MISS  = 2'd2
    } ack_state_t;
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
    import irq_pair_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int VW = VEC_W,
    parameter logic [VW-1:0] VEC_RST = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [VW-1:0] wdata,
    output logic [LW-1:0] spi_lvl,
    output logic [LW-1:0] uart_lvl,
    output logic [VW-2:0] vec_hi,
    output logic [VW-1:0] rdata
);
    localparam int PAD = VW - LW;

    logic [LW-1:0] lvl_q [NSRC];
    logic [VW-2:0] vec_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[s] <= '0;
            end else if (wr_en && (sel == 2'(s))) begin
                lvl_q[s] <= wdata[LW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= VEC_RST[VW-1:1];
        end else if (wr_en && (sel == SEL_VECTOR)) begin
            vec_q <= wdata[VW-1:1];
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SPI_LVL:  rdata = {{PAD{1'b0}}, lvl_q[SRC_SPI]};
            SEL_UART_LVL: rdata = {{PAD{1'b0}}, lvl_q[SRC_UART]};
            SEL_VECTOR:   rdata = {vec_q, 1'b1};
            default:      rdata = '0;
        endcase
    end

    assign spi_lvl  = lvl_q[SRC_SPI];
    assign uart_lvl = lvl_q[SRC_UART];
    assign vec_hi   = vec_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pair_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic [LW-1:0] spi_lvl,
    input  logic [LW-1:0] uart_lvl,
    input  logic          spi_req,
    input  logic          uart_req,
    input  logic [LW-1:0] ack_level,
    output logic [LW-1:0] irq_level,
    output logic          match,
    output logic          spi_won
);
    logic spi_live, uart_live;
    logic spi_match, uart_match;
    logic [LW-1:0] spi_eff, uart_eff;

    always_comb begin
        spi_live  = spi_req  && (spi_lvl  != '0);
        uart_live = uart_req && (uart_lvl != '0);
        spi_eff   = spi_live  ? spi_lvl  : '0;
        uart_eff  = uart_live ? uart_lvl : '0;
        irq_level = (spi_eff >= uart_eff) ? spi_eff : uart_eff;
        spi_match  = spi_live  && (spi_lvl  == ack_level);
        uart_match = uart_live && (uart_lvl == ack_level);
        match   = spi_match || uart_match;
        spi_won = spi_match;
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pair_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_start,
    input  logic          ack_end,
    input  logic          match,
    input  logic          spi_won,
    input  logic [VW-2:0] vec_hi,
    output logic          ack_hit,
    output logic [VW-1:0] ack_vector,
    output logic          busy
);
    ack_state_t state_q, state_d;
    logic [VW-1:0] vec_cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: begin
                if (ack_start) state_d = match ? ACK_SERVE : ACK_MISS;
            end
            ACK_SERVE: begin
                if (ack_end) state_d = ACK_IDLE;
            end
            ACK_MISS: begin
                if (ack_end) state_d = ACK_IDLE;
            end
            default: state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_cap_q <= '0;
        end else if ((state_q == ACK_IDLE) && ack_start) begin
            vec_cap_q <= {vec_hi, spi_won};
        end
    end

    always_comb begin
        ack_hit    = (state_q == ACK_SERVE);
        ack_vector = ack_hit ? vec_cap_q : '0;
        busy       = (state_q != ACK_IDLE);
    end
endmodule

// File: rtl/irq_pair_vec.sv
module irq_pair_vec
    import irq_pair_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_sel,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    input  logic         spi_req,
    input  logic         uart_req,
    output logic [2:0]   irq_level,
    input  logic         ack_start,
    input  logic [2:0]   ack_level,
    input  logic         ack_end,
    output logic         ack_hit,
    output logic [7:0]   ack_vector
);
    logic [LVL_W-1:0] spi_lvl, uart_lvl;
    logic [VEC_W-2:0] vec_hi;
    logic match, spi_won, busy;

    irq_lvl_regs #(.LW(LVL_W), .VW(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
        .wdata(reg_wdata), .spi_lvl(spi_lvl), .uart_lvl(uart_lvl),
        .vec_hi(vec_hi), .rdata(reg_rdata)
    );

    irq_arb #(.LW(LVL_W)) u_arb (
        .spi_lvl(spi_lvl), .uart_lvl(uart_lvl),
        .spi_req(spi_req), .uart_req(uart_req),
        .ack_level(ack_level), .irq_level(irq_level),
        .match(match), .spi_won(spi_won)
    );

    irq_ack_fsm #(.VW(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .ack_end(ack_end),
        .match(match), .spi_won(spi_won), .vec_hi(vec_hi),
        .ack_hit(ack_hit), .ack_vector(ack_vector), .busy(busy)
    );
endmodule

// File: rtl/irq_pair_vec_chk.sv
module irq_pair_vec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_req,
    input logic       uart_req,
    input logic [2:0] spi_lvl,
    input logic [2:0] uart_lvl,
    input logic [2:0] irq_level,
    input logic       ack_start,
    input logic       ack_end,
    input logic [2:0] ack_level,
    input logic       ack_hit,
    input logic [7:0] ack_vector,
    input logic       busy
);
    p_spi_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && spi_lvl != 3'd0) |-> (irq_level >= spi_lvl));

    p_uart_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_req && uart_lvl != 3'd0) |-> (irq_level >= uart_lvl));

    p_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_req && !uart_req) |-> (irq_level == 3'd0));

    p_hit_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && !busy && spi_req && spi_lvl != 3'd0 && spi_lvl == ack_level)
        |=> (ack_hit && ack_vector[0]));

    p_tie_spi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && !busy && spi_req && uart_req && spi_lvl == uart_lvl
         && spi_lvl == ack_level && ack_level != 3'd0) |=> ack_vector[0]);

    p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && !busy && ack_level == 3'd0) |=> !ack_hit);

    p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !ack_end) |=> (ack_hit && $stable(ack_vector)));

    p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_end) |=> (!ack_hit && !busy));
endmodule

bind irq_pair_vec irq_pair_vec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_req(spi_req), .uart_req(uart_req),
    .spi_lvl(spi_lvl), .uart_lvl(uart_lvl), .irq_level(irq_level),
    .ack_start(ack_start), .ack_end(ack_end), .ack_level(ack_level),
    .ack_hit(ack_hit), .ack_vector(ack_vector), .busy(busy)
);

// File: tb/irq_pair_vec_bench.sv
module irq_pair_vec_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       spi_req = 1'b0;
    logic       uart_req = 1'b0;
    logic [2:0] irq_level;
    logic       ack_start = 1'b0;
    logic [2:0] ack_level = 3'd0;
    logic       ack_end = 1'b0;
    logic       ack_hit;
    logic [7:0] ack_vector;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_pair_vec u_irq_pair_vec (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_req(spi_req), .uart_req(uart_req), .irq_level(irq_level),
        .ack_start(ack_start), .ack_level(ack_level), .ack_end(ack_end),
        .ack_hit(ack_hit), .ack_vector(ack_vector)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic open_ack(input logic [2:0] lvl);
        @(negedge clk);
        ack_start = 1'b1; ack_level = lvl;
        @(negedge clk);
        ack_start = 1'b0;
    endtask

    task automatic close_ack();
        @(negedge clk);
        ack_end = 1'b1;
        @(negedge clk);
        ack_end = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 spi level", 2'd0, 8'h00);
        rd_check("R1 uart level", 2'd1, 8'h00);
        rd_check("R1 vector", 2'd2, 8'h0F);
        check("R1 irq_level", {5'd0, irq_level}, 8'h00);
        check("R1 ack_hit", {7'd0, ack_hit}, 8'h00);
    endtask

    task automatic t_levels_rw();
        wr(2'd0, 8'h05);
        rd_check("R2 spi level", 2'd0, 8'h05);
        wr(2'd1, 8'hFB);
        rd_check("R2 uart level masked", 2'd1, 8'h03);
        rd_check("R2 spi untouched", 2'd0, 8'h05);
        rd_check("R2 select 3", 2'd3, 8'h00);
    endtask

    task automatic t_vector_rw();
        wr(2'd2, 8'h40);
        rd_check("R3 vector lsb reads 1", 2'd2, 8'h41);
        wr(2'd2, 8'h83);
        rd_check("R3 vector", 2'd2, 8'h83);
        wr(2'd2, 8'h80);
        rd_check("R3 vector lsb write ignored", 2'd2, 8'h81);
    endtask

    task automatic t_level_out();
        wr(2'd0, 8'h05); wr(2'd1, 8'h03);
        @(negedge clk); spi_req = 1'b1; uart_req = 1'b0; #1;
        check("R4 spi only", {5'd0, irq_level}, 8'h05);
        spi_req = 1'b0; uart_req = 1'b1; #1;
        check("R4 uart only", {5'd0, irq_level}, 8'h03);
        spi_req = 1'b1; #1;
        check("R4 both max", {5'd0, irq_level}, 8'h05);
        wr(2'd0, 8'h00); #1;
        check("R4 disabled spi ignored", {5'd0, irq_level}, 8'h03);
        wr(2'd1, 8'h00); #1;
        check("R4 both disabled", {5'd0, irq_level}, 8'h00);
        spi_req = 1'b0; uart_req = 1'b0;
    endtask

    task automatic t_ack_basic();
        wr(2'd0, 8'h05); wr(2'd1, 8'h03);
        spi_req = 1'b1; uart_req = 1'b1;
        open_ack(3'd5);
        check("R5 spi hit", {7'd0, ack_hit}, 8'h01);
        check("R5 spi vector", ack_vector, 8'h81);
        close_ack();
        open_ack(3'd3);
        check("R5 uart vector", ack_vector, 8'h80);
        close_ack();
        spi_req = 1'b0; uart_req = 1'b0;
    endtask

    task automatic t_tie();
        wr(2'd0, 8'h04); wr(2'd1, 8'h04);
        spi_req = 1'b1; uart_req = 1'b1;
        open_ack(3'd4);
        check("R6 tie spi wins", ack_vector, 8'h81);
        close_ack();
        spi_req = 1'b0; uart_req = 1'b0;
    endtask

    task automatic t_miss();
        wr(2'd0, 8'h05);
        spi_req = 1'b1;
        open_ack(3'd2);
        check("R7 miss hit", {7'd0, ack_hit}, 8'h00);
        check("R7 miss vector", ack_vector, 8'h00);
        close_ack();
        open_ack(3'd5);
        check("R7 hit after miss", ack_vector, 8'h81);
        close_ack();
        spi_req = 1'b0;
    endtask

    task automatic t_freeze();
        wr(2'd0, 8'h04); wr(2'd1, 8'h04);
        uart_req = 1'b1;
        open_ack(3'd4);
        check("R8 uart at start", ack_vector, 8'h80);
        spi_req = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R8 vector frozen", ack_vector, 8'h80);
        ack_start = 1'b1; ack_level = 3'd4;
        @(negedge clk);
        ack_start = 1'b0;
        check("R9 second start ignored", ack_vector, 8'h80);
        close_ack();
        check("R9 end clears hit", {7'd0, ack_hit}, 8'h00);
        spi_req = 1'b0; uart_req = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_levels_rw();
        t_vector_rw();
        t_level_out();
        t_ack_basic();
        t_tie();
        t_miss();
        t_freeze();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule